// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of a serial port and serves them to a CPU over a small register bus that has an address, a read strobe, a write strobe and a data byte. The transmitter and receiver report events to it through single-cycle strobes. It keeps five event flags that software clears: transmit buffer empty, receive buffer full, overrun, framing error and parity error. It also keeps a read-only transmit-end bit, a read-only copy of the last received multiprocessor bit, and one plain read/write bit that sets the multiprocessor bit for the next outgoing frame.

Software can clear a flag only by writing 0 to it after a read has returned that flag as 1. Each clearable flag has its own arm latch. A read that returns the flag as 1 arms the latch, and any write to the register disarms it. Because of this, an event that arrives after software last looked at the flag cannot be wiped out by accident. When an event and a clearing write land in the same cycle, the flag stays set. A write from a transfer engine into the transmit data register clears the transmit-empty flag directly, with no read needed first.

Top module: `sci_flag_reg`

## Requirements
- R1: When `rd_i` is high and `addr_i` equals `REG_ADDR`, `rdata_o` shows the register in the same cycle, with bit 7 = transmit-empty, 6 = receive-full, 5 = overrun, 4 = framing error, 3 = parity error, 2 = transmit-end, 1 = received MP bit and 0 = MP bit to send. At any other time `rdata_o` is 0. Reads and writes at any other address have no effect.
- R2: A synchronous `rst`, or `lowpwr_i` high at a clock edge, loads the register with 0x84 and disarms every arm latch.
- R3: Writing 1 to any of bits 7..3 leaves that bit unchanged.
- R4: A write with a 0 in one of bits 7..3 clears that flag only if a read since the last write returned the flag as 1. Every write to the register disarms all latches.
- R5: When a set event and a clearing write or transfer-engine write fall in the same cycle, the flag ends that cycle at 1.
- R6: Pulses on `rx_full_i`, `rx_ovr_i`, `rx_frm_i` and `rx_par_i` set bits 6, 5, 4 and 3 at the next edge.
- R7: While `tx_en_i` is 0, bit 7 reads as 1 from the next edge onward. A `tx_load_i` pulse sets bit 7.
- R8: A `dma_wr_i` pulse clears bit 7 with no read needed first.
- R9: Bit 2 is set by a `tx_end_i` pulse and cleared in the same cycle that bit 7 is cleared. Writes do not change it.
- R10: A `rx_done_i` pulse loads bit 1 from `rx_mpb_i`. Writes do not change it.
- R11: A write to the register loads bit 0 from `wdata_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr_i | input | 1 | Standby or module-stop request; reinitialises the register |
| addr_i | input | ADDR_W | Register bus address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the strobe |
| tx_en_i | input | 1 | Transmitter enable |
| tx_load_i | input | 1 | Data register moved into the shift register |
| dma_wr_i | input | 1 | Transfer engine wrote the transmit data register |
| tx_end_i | input | 1 | Transmission finished with no data pending |
| rx_full_i | input | 1 | Received byte available |
| rx_ovr_i | input | 1 | Overrun detected |
| rx_frm_i | input | 1 | Framing error detected |
| rx_par_i | input | 1 | Parity error detected |
| rx_done_i | input | 1 | Frame received; loads the MP bit |
| rx_mpb_i | input | 1 | Received multiprocessor bit value |
| flags_o | output | 8 | Current register contents for the transmitter and interrupt logic |

## Verification
The bench builds the block with `ADDR_W` = 3 and `REG_ADDR` = 5, which is not the default. This shows that decoding follows the parameters, and it lets the bench send reads and writes to a neighbouring address to confirm that they return 0 and change nothing. The stimulus covers the cases the arm latch exists for:
- an unarmed write of 0;
- a write of 0 that arrives together with a new event;
- an arm that is lost across the low-power reinitialisation;
- a transfer-engine write coinciding with a load pulse.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;

    localparam int REG_W    = 8;
    localparam int CLR_LO   = 3;
    localparam int CLR_HI   = 7;
    localparam int B_TXE    = 7;
    localparam int B_RXF    = 6;
    localparam int B_OVR    = 5;
    localparam int B_FRM    = 4;
    localparam int B_PAR    = 3;
    localparam int B_TEND   = 2;
    localparam int B_MPB    = 1;
    localparam int B_MPBT   = 0;
    localparam logic [REG_W-1:0] INIT_VAL = 8'h84;

    typedef struct packed {
        logic txe;
        logic rxf;
        logic ovr;
        logic frm;
        logic par;
        logic tend;
        logic mpb;
        logic mpbt;
    } stat_t;

    typedef struct packed {
        logic             rd_hit;
        logic             wr_hit;
        logic [REG_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [REG_W-1:0] stat_pack(input stat_t s);
        return {s.txe, s.rxf, s.ovr, s.frm, s.par, s.tend, s.mpb, s.mpbt};
    endfunction

endpackage

// File: rtl/sci_flag_dec.sv
module sci_flag_dec
    import sci_flag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  cur_i,
    output bus_req_t          req_o,
    output logic [REG_W-1:0]  rdata_o
);
    logic hit;

    always_comb begin
        hit          = (addr_i == REG_ADDR);
        req_o.rd_hit = hit & rd_i;
        req_o.wr_hit = hit & wr_i;
        req_o.wdata  = wdata_i;
        rdata_o      = req_o.rd_hit ? cur_i : '0;
    end
endmodule

// File: rtl/sci_clr_flag.sv
module sci_clr_flag #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lowpwr_i,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic wbit_i,
    input  logic set_i,
    input  logic hold_i,
    input  logic hwclr_i,
    output logic flag_o,
    output logic clr_o
);
    logic flag_q, arm_q;
    logic flag_d, arm_d, clr_req;

    always_comb begin
        clr_req = (wr_hit_i & ~wbit_i & arm_q) | hwclr_i;
        if (set_i | hold_i)
            flag_d = 1'b1;
        else if (clr_req)
            flag_d = 1'b0;
        else
            flag_d = flag_q;
        if (wr_hit_i)
            arm_d = 1'b0;
        else if (rd_hit_i & flag_q)
            arm_d = 1'b1;
        else
            arm_d = arm_q;
        clr_o = flag_q & ~flag_d;
    end

    always_ff @(posedge clk) begin
        if (rst || lowpwr_i) begin
            flag_q <= INIT;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sci_aux_bits.sv
module sci_aux_bits
    import sci_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lowpwr_i,
    input  bus_req_t req_i,
    input  logic     tx_end_i,
    input  logic     txe_clr_i,
    input  logic     rx_done_i,
    input  logic     rx_mpb_i,
    output logic     tend_o,
    output logic     mpb_o,
    output logic     mpbt_o
);
    logic tend_q, mpb_q, mpbt_q;

    always_ff @(posedge clk) begin
        if (rst || lowpwr_i) begin
            tend_q <= INIT_VAL[B_TEND];
            mpb_q  <= INIT_VAL[B_MPB];
            mpbt_q <= INIT_VAL[B_MPBT];
        end else begin
            if (tx_end_i)
                tend_q <= 1'b1;
            else if (txe_clr_i)
                tend_q <= 1'b0;
            if (rx_done_i)
                mpb_q <= rx_mpb_i;
            if (req_i.wr_hit)
                mpbt_q <= req_i.wdata[B_MPBT];
        end
    end

    assign tend_o = tend_q;
    assign mpb_o  = mpb_q;
    assign mpbt_o = mpbt_q;
endmodule

// File: rtl/sci_flag_reg.sv
module sci_flag_reg
    import sci_flag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lowpwr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic              tx_en_i,
    input  logic              tx_load_i,
    input  logic              dma_wr_i,
    input  logic              tx_end_i,
    input  logic              rx_full_i,
    input  logic              rx_ovr_i,
    input  logic              rx_frm_i,
    input  logic              rx_par_i,
    input  logic              rx_done_i,
    input  logic              rx_mpb_i,
    output logic [7:0]        flags_o
);
    bus_req_t         req;
    stat_t            st;
    logic [REG_W-1:0] cur;
    logic [REG_W-1:0] set_v, hold_v, hwclr_v, flag_v, clr_v;

    assign cur = stat_pack(st);

    sci_flag_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr_i (addr_i),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .wdata_i(wdata_i),
        .cur_i  (cur),
        .req_o  (req),
        .rdata_o(rdata_o)
    );

    always_comb begin
        set_v          = '0;
        hold_v         = '0;
        hwclr_v        = '0;
        set_v[B_TXE]   = tx_load_i;
        hold_v[B_TXE]  = ~tx_en_i;
        hwclr_v[B_TXE] = dma_wr_i;
        set_v[B_RXF]   = rx_full_i;
        set_v[B_OVR]   = rx_ovr_i;
        set_v[B_FRM]   = rx_frm_i;
        set_v[B_PAR]   = rx_par_i;
    end

    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g >= CLR_LO && g <= CLR_HI) begin : g_clr
            sci_clr_flag #(.INIT(INIT_VAL[g])) u_flag (
                .clk     (clk),
                .rst     (rst),
                .lowpwr_i(lowpwr_i),
                .rd_hit_i(req.rd_hit),
                .wr_hit_i(req.wr_hit),
                .wbit_i  (req.wdata[g]),
                .set_i   (set_v[g]),
                .hold_i  (hold_v[g]),
                .hwclr_i (hwclr_v[g]),
                .flag_o  (flag_v[g]),
                .clr_o   (clr_v[g])
            );
        end else begin : g_none
            assign flag_v[g] = 1'b0;
            assign clr_v[g]  = 1'b0;
        end
    end

    sci_aux_bits u_aux (
        .clk      (clk),
        .rst      (rst),
        .lowpwr_i (lowpwr_i),
        .req_i    (req),
        .tx_end_i (tx_end_i),
        .txe_clr_i(clr_v[B_TXE]),
        .rx_done_i(rx_done_i),
        .rx_mpb_i (rx_mpb_i),
        .tend_o   (st.tend),
        .mpb_o    (st.mpb),
        .mpbt_o   (st.mpbt)
    );

    assign st.txe = flag_v[B_TXE];
    assign st.rxf = flag_v[B_RXF];
    assign st.ovr = flag_v[B_OVR];
    assign st.frm = flag_v[B_FRM];
    assign st.par = flag_v[B_PAR];

    assign flags_o = cur;
endmodule

// File: rtl/sci_flag_chk.sv
module sci_flag_chk #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h4
) (
    input logic              clk,
    input logic              rst,
    input logic              lowpwr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        rdata_o,
    input logic              tx_en_i,
    input logic              tx_load_i,
    input logic              dma_wr_i,
    input logic              tx_end_i,
    input logic              rx_full_i,
    input logic              rx_ovr_i,
    input logic              rx_frm_i,
    input logic              rx_par_i,
    input logic              rx_done_i,
    input logic              rx_mpb_i,
    input logic [7:0]        flags_o
);
    logic rd_hit, wr_hit, seen_rxf;

    assign rd_hit = rd_i && (addr_i == REG_ADDR);
    assign wr_hit = wr_i && (addr_i == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst || lowpwr_i || wr_hit)
            seen_rxf <= 1'b0;
        else if (rd_hit && rdata_o[6])
            seen_rxf <= 1'b1;
    end

    p_miss_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> rdata_o == 8'h00);
    p_lowpwr_init_r2: assert property (@(posedge clk) disable iff (rst)
        lowpwr_i |=> flags_o == 8'h84);
    p_wr_one_r3: assert property (@(posedge clk) disable iff (rst)
        wr_hit && wdata_i[5] && !flags_o[5] && !rx_ovr_i |=> !flags_o[5]);
    p_unarmed_keep_r4: assert property (@(posedge clk) disable iff (rst)
        flags_o[6] && !seen_rxf && !lowpwr_i |=> flags_o[6]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        rx_full_i && !lowpwr_i |=> flags_o[6]);
    p_te_low_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_en_i |=> flags_o[7]);
    p_mpb_ro_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_done_i && !lowpwr_i |=> $stable(flags_o[1]));
    p_mpbt_wr_r11: assert property (@(posedge clk) disable iff (rst)
        wr_hit && !lowpwr_i |=> flags_o[0] == $past(wdata_i[0]));
endmodule

bind sci_flag_reg sci_flag_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/sim_sci_flag_reg.sv
module sim_sci_flag_reg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] RA = 3'd5;
    localparam logic [ADDR_W-1:0] OTHER = 3'd4;

    logic clk = 1'b0, rst = 1'b1, lowpwr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0, rdata, flags;
    logic tx_en = 1'b0, tx_load = 1'b0, dma_wr = 1'b0, tx_end = 1'b0;
    logic rx_full = 1'b0, rx_ovr = 1'b0, rx_frm = 1'b0, rx_par = 1'b0;
    logic rx_done = 1'b0, rx_mpb = 1'b0;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    sci_flag_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) u0 (
        .clk(clk), .rst(rst), .lowpwr_i(lowpwr), .addr_i(addr), .rd_i(rd),
        .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .tx_en_i(tx_en),
        .tx_load_i(tx_load), .dma_wr_i(dma_wr), .tx_end_i(tx_end),
        .rx_full_i(rx_full), .rx_ovr_i(rx_ovr), .rx_frm_i(rx_frm),
        .rx_par_i(rx_par), .rx_done_i(rx_done), .rx_mpb_i(rx_mpb),
        .flags_o(flags)
    );

    // event mask bits: 0 full, 1 ovr, 2 frm, 3 par, 4 done, 5 mpb, 6 load, 7 dma, 8 tend, 9 lowpwr
    task automatic set_ev(input logic [9:0] m);
        rx_full = m[0]; rx_ovr = m[1]; rx_frm = m[2]; rx_par = m[3];
        rx_done = m[4]; rx_mpb = m[5]; tx_load = m[6]; dma_wr = m[7];
        tx_end = m[8]; lowpwr = m[9];
    endtask

    task automatic ev(input logic [9:0] m);
        @(negedge clk);
        set_ev(m);
        @(negedge clk);
        set_ev('0);
    endtask

    task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_ev(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [9:0] m);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        set_ev(m);
        @(negedge clk);
        wr = 1'b0;
        set_ev('0);
    endtask

    // monitor: compares every read against the scoreboard queue
    initial forever begin
        @(negedge clk);
        #1;
        if (rd) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read, got %02h expected none", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_exp(RA, 8'h84, "R2 reset value");
        rd_exp(OTHER, 8'h00, "R1 other address reads 0");
        wr_ev(RA, 8'h00, '0);
        rd_exp(RA, 8'h84, "R7 TDRE held while disabled");
        @(negedge clk); tx_en = 1'b1;
        ev(10'h005);
        rd_exp(RA, 8'hD4, "R6 receive-full and framing set");
        wr_ev(RA, 8'hFE, '0);
        wr_ev(RA, 8'h00, '0);
        rd_exp(RA, 8'hD4, "R4 unarmed write 0 keeps flags");
        wr_ev(RA, 8'hBF, '0);
        rd_exp(RA, 8'h95, "R4 armed clear of receive-full, R11 MPBT=1");
        wr_ev(RA, 8'h00, 10'h004);
        rd_exp(RA, 8'h10, "R5 framing set wins; R9 TEND cleared with TDRE");
        wr_ev(RA, 8'hFF, '0);
        rd_exp(RA, 8'h11, "R3 writing 1 leaves overrun 0");
        ev(10'h040);
        rd_exp(RA, 8'h91, "R7 load pulse sets TDRE");
        ev(10'h100);
        rd_exp(RA, 8'h95, "R9 tx_end sets TEND");
        wr_ev(RA, 8'hFB, '0);
        rd_exp(RA, 8'h95, "R9 write 0 to TEND ignored");
        ev(10'h080);
        rd_exp(RA, 8'h11, "R8 transfer-engine write clears TDRE and TEND");
        ev(10'h0C0);
        rd_exp(RA, 8'h91, "R5 load beats transfer-engine clear");
        ev(10'h030);
        rd_exp(RA, 8'h93, "R10 MPB loaded as 1");
        wr_ev(RA, 8'h00, '0);
        rd_exp(RA, 8'h02, "R10 MPB survives write; R4 armed flags cleared");
        ev(10'h010);
        rd_exp(RA, 8'h00, "R10 MPB loaded as 0");
        ev(10'h008);
        rd_exp(RA, 8'h08, "R6 parity set");
        ev(10'h200);
        rd_exp(RA, 8'h84, "R2 low-power reinitialises");
        ev(10'h008);
        wr_ev(RA, 8'hF7, '0);
        rd_exp(RA, 8'h8D, "R2 arm dropped by low-power");
        wr_ev(OTHER, 8'h00, '0);
        rd_exp(RA, 8'h8D, "R1 write elsewhere ignored");
        ev(10'h002);
        rd_exp(RA, 8'hAD, "R6 overrun set");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule